// File: doc/BRIEF.md
# Four-Wide Register Rename Unit with Branch Checkpoints

The block renames a group of up to four decoded instructions every cycle. Each architected source is turned into a physical tag by reading a speculative map table. Each destination receives a fresh physical register from a free list. Tags handed to earlier slots of the same group are forwarded to later slots within the cycle. A second map, the committed map, follows retirement. It decides which physical register is released when an instruction retires, and it can be copied back into the speculative map for a full recovery.

Every branch in an accepted group takes a checkpoint slot. The slot holds the speculative map and the free list as they stand just after that branch. A mispredict restores both in one cycle and releases that checkpoint and every younger one. Registers released by retirement are merged into every stored checkpoint, so a rollback never revives a register that has already been freed. The group is accepted or held as a whole. It is held when physical registers or checkpoint slots run short, or when the downstream queues report full.

Top module: `reg_rename`

## Requirements
- R1: After reset, architected register a maps to physical register a, physical registers NUM_ARCH..NUM_PHYS-1 are free, no checkpoint is in use and the committed map is the identity.
- R2: The source tags of slot k equal the speculative mapping as updated by the destinations of valid slots 0..k-1 of the same group.
- R3: Each valid slot with a destination receives the lowest-numbered free physical register not taken by an earlier slot of the group. Its old tag output is the mapping of its destination before that slot. A slot without an allocation shows destination tag 0.
- R4: stall_o is high when the group needs more destinations than there are free physical registers. A held group changes neither the map nor the free list.
- R5: stall_o is high whenever rob_full_i or iq_full_i is high, and no group is accepted then.
- R6: ren_fire_o equals no stall and no flush. Branch slots of an accepted group get checkpoint numbers tail, tail+1, … in slot order, modulo NUM_CKPT, where tail is the oldest live number plus the live count. stall_o is high when the group has more branches than there are free checkpoint slots.
- R7: On br_mispredict_i with number c, the next-cycle speculative map and free list are the state saved right after that branch, plus registers freed by commits since then. Slot c and all younger slots are released. The group presented in that cycle is not accepted.
- R8: A valid commit of (arch, tag) writes the committed map. The tag it replaces becomes free from the next cycle on, and it is merged into every saved checkpoint. Mispredicts never alter the committed map.
- R9: recover_i copies the committed map, including that cycle's commits, into the speculative map. It frees every physical register that the committed map does not reference, drops all checkpoints and takes priority over a mispredict.
- R10: br_resolve_i without a flush releases the oldest live checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | WIDTH | Slot holds an instruction |
| ren_has_dst_i | input | WIDTH | Slot writes a destination |
| ren_is_br_i | input | WIDTH | Slot is a branch needing a checkpoint |
| ren_dst_i | input | WIDTH*AW | Architected destination per slot |
| ren_src1_i | input | WIDTH*AW | First architected source per slot |
| ren_src2_i | input | WIDTH*AW | Second architected source per slot |
| rob_full_i | input | 1 | Reorder buffer cannot take a group |
| iq_full_i | input | 1 | Issue queue cannot take a group |
| stall_o | output | 1 | Group held this cycle |
| ren_fire_o | output | 1 | Group accepted this cycle |
| ren_src1_tag_o | output | WIDTH*PW | Physical tag of first source |
| ren_src2_tag_o | output | WIDTH*PW | Physical tag of second source |
| ren_dst_tag_o | output | WIDTH*PW | Newly allocated destination tag |
| ren_old_tag_o | output | WIDTH*PW | Previous mapping of the destination |
| ren_ckpt_o | output | WIDTH*CW | Checkpoint number of each branch slot |
| cmt_valid_i | input | WIDTH | Commit slot valid, in program order |
| cmt_arch_i | input | WIDTH*AW | Architected register being retired |
| cmt_tag_i | input | WIDTH*PW | Physical tag being retired |
| br_resolve_i | input | 1 | Oldest live branch resolved correctly |
| br_mispredict_i | input | 1 | Branch with number br_ckpt_i mispredicted |
| br_ckpt_i | input | CW | Checkpoint number of the mispredicted branch |
| recover_i | input | 1 | Restore from the committed map |

## Verification
A legal random instruction stream is checked against a bench model that keeps its own maps, free vector, checkpoints and a program-ordered retirement window. The stream mixes groups in which later slots read and rewrite registers written by earlier slots, which separates intra-group forwarding from plain table reads. Checkpoint counts run up to saturation, so branch stalls are distinguished from register shortage. Mispredicts are aimed at arbitrary live checkpoints in the same cycles as commits, which shows whether freed registers survive a rollback. Occasional full recoveries and a directed first group after reset expose the committed map and the reset identity through the source tags.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_ARCH  = 32;
  localparam int unsigned RN_PHYS  = 64;
  localparam int unsigned RN_WIDTH = 4;
  localparam int unsigned RN_CKPT  = 4;  // must be a power of two
endpackage

// File: rtl/rn_group_chain.sv
module rn_group_chain #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned WIDTH    = 4,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_ARCH-1:0][PW-1:0] map_i,
  input  logic [NUM_PHYS-1:0]         free_i,
  input  logic [WIDTH-1:0]            alloc_i,
  input  logic [WIDTH-1:0][AW-1:0]    dst_i,
  input  logic [WIDTH-1:0][AW-1:0]    src1_i,
  input  logic [WIDTH-1:0][AW-1:0]    src2_i,
  output logic [WIDTH-1:0][PW-1:0]    src1_tag_o,
  output logic [WIDTH-1:0][PW-1:0]    src2_tag_o,
  output logic [WIDTH-1:0][PW-1:0]    dst_tag_o,
  output logic [WIDTH-1:0][PW-1:0]    old_tag_o,
  output logic [NUM_ARCH-1:0][PW-1:0] map_stage_o [WIDTH],
  output logic [NUM_PHYS-1:0]         free_stage_o [WIDTH]
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_slot
    logic [NUM_ARCH-1:0][PW-1:0] m_in, m_out;
    logic [NUM_PHYS-1:0]         f_in, f_out;
    logic [PW-1:0]               pick;

    if (k == 0) begin : g_head
      assign m_in = map_i;
      assign f_in = free_i;
    end else begin : g_link
      assign m_in = map_stage_o[k-1];
      assign f_in = free_stage_o[k-1];
    end

    always_comb begin
      pick = '0;
      for (int p = NUM_PHYS - 1; p >= 0; p--) begin
        if (f_in[p]) pick = PW'(p);
      end
      m_out = m_in;
      f_out = f_in;
      if (alloc_i[k]) begin
        m_out[dst_i[k]] = pick;
        f_out[pick]     = 1'b0;
      end
    end

    assign src1_tag_o[k]   = m_in[src1_i[k]];
    assign src2_tag_o[k]   = m_in[src2_i[k]];
    assign old_tag_o[k]    = m_in[dst_i[k]];
    assign dst_tag_o[k]    = alloc_i[k] ? pick : '0;
    assign map_stage_o[k]  = m_out;
    assign free_stage_o[k] = f_out;
  end
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned WIDTH    = 4,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [WIDTH-1:0]            cmt_valid_i,
  input  logic [WIDTH-1:0][AW-1:0]    cmt_arch_i,
  input  logic [WIDTH-1:0][PW-1:0]    cmt_tag_i,
  output logic [NUM_ARCH-1:0][PW-1:0] cmap_next_o,
  output logic [NUM_PHYS-1:0]         freed_o,
  output logic [NUM_PHYS-1:0]         recov_free_o
);
  logic [NUM_ARCH-1:0][PW-1:0] cmap_q;
  logic [NUM_ARCH-1:0][PW-1:0] stage [WIDTH];
  logic [NUM_PHYS-1:0]         slot_freed [WIDTH];

  for (genvar k = 0; k < WIDTH; k++) begin : g_cmt
    logic [NUM_ARCH-1:0][PW-1:0] c_in, c_out;
    logic [NUM_PHYS-1:0]         fm;
    if (k == 0) begin : g_head
      assign c_in = cmap_q;
    end else begin : g_link
      assign c_in = stage[k-1];
    end
    always_comb begin
      c_out = c_in;
      fm    = '0;
      if (cmt_valid_i[k]) begin
        fm[c_in[cmt_arch_i[k]]] = 1'b1;  // tag being displaced
        c_out[cmt_arch_i[k]]    = cmt_tag_i[k];
      end
    end
    assign stage[k]      = c_out;
    assign slot_freed[k] = fm;
  end

  assign cmap_next_o = stage[WIDTH-1];

  always_comb begin
    freed_o = '0;
    for (int k = 0; k < WIDTH; k++) freed_o |= slot_freed[k];
  end

  always_comb begin
    logic [NUM_PHYS-1:0] used;
    used = '0;
    for (int a = 0; a < NUM_ARCH; a++) used[cmap_next_o[a]] = 1'b1;
    recov_free_o = ~used;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) cmap_q[a] <= PW'(a);
    end else begin
      cmap_q <= cmap_next_o;
    end
  end
endmodule

// File: rtl/rn_ckpt_store.sv
module rn_ckpt_store #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned NUM_CKPT = 4,
  localparam int unsigned PW   = $clog2(NUM_PHYS),
  localparam int unsigned CW   = $clog2(NUM_CKPT),
  localparam int unsigned CNTW = $clog2(NUM_CKPT + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        take_i,
  input  logic [WIDTH-1:0]            br_i,
  input  logic [NUM_ARCH-1:0][PW-1:0] map_stage_i [WIDTH],
  input  logic [NUM_PHYS-1:0]         free_stage_i [WIDTH],
  input  logic [NUM_PHYS-1:0]         freed_i,
  input  logic                        resolve_i,
  input  logic                        mispredict_i,
  input  logic [CW-1:0]               mis_id_i,
  input  logic                        clear_i,
  output logic [WIDTH-1:0][CW-1:0]    slot_id_o,
  output logic                        room_ok_o,
  output logic [NUM_ARCH-1:0][PW-1:0] rest_map_o,
  output logic [NUM_PHYS-1:0]         rest_free_o
);
  logic [NUM_ARCH-1:0][PW-1:0] ck_map_q  [NUM_CKPT];
  logic [NUM_PHYS-1:0]         ck_free_q [NUM_CKPT];
  logic [CW-1:0]               head_q, tail;
  logic [CNTW-1:0]             cnt_q, n_br, keep_cnt;

  assign tail     = head_q + CW'(cnt_q);
  assign keep_cnt = CNTW'(CW'(mis_id_i - head_q));

  always_comb begin
    n_br = '0;
    for (int k = 0; k < WIDTH; k++) begin
      slot_id_o[k] = tail + CW'(n_br);
      if (br_i[k]) n_br = n_br + 1'b1;
    end
  end

  assign room_ok_o   = (int'(n_br) + int'(cnt_q)) <= NUM_CKPT;
  assign rest_map_o  = ck_map_q[mis_id_i];
  assign rest_free_o = ck_free_q[mis_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CKPT; c++) begin
        ck_map_q[c]  <= '0;
        ck_free_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CKPT; c++) begin
        ck_free_q[c] <= ck_free_q[c] | freed_i;  // retired tags stay free across rollback
        for (int k = 0; k < WIDTH; k++) begin
          if (take_i && br_i[k] && slot_id_o[k] == CW'(c)) begin
            ck_map_q[c]  <= map_stage_i[k];
            ck_free_q[c] <= free_stage_i[k] | freed_i;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (mispredict_i) begin
      cnt_q <= keep_cnt;
    end else begin
      head_q <= head_q + CW'(resolve_i);
      cnt_q  <= cnt_q - CNTW'(resolve_i) + (take_i ? n_br : '0);
    end
  end

  AST_MIS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispredict_i && !clear_i) |-> (keep_cnt < cnt_q)); // R7
  AST_RESOLVE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_i && !mispredict_i && !clear_i) |-> (cnt_q != '0)); // R10
  AST_CKPT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_q) <= NUM_CKPT)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rn_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RN_ARCH,
  parameter int unsigned NUM_PHYS = RN_PHYS,
  parameter int unsigned WIDTH    = RN_WIDTH,
  parameter int unsigned NUM_CKPT = RN_CKPT,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_CKPT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WIDTH-1:0]         ren_valid_i,
  input  logic [WIDTH-1:0]         ren_has_dst_i,
  input  logic [WIDTH-1:0]         ren_is_br_i,
  input  logic [WIDTH-1:0][AW-1:0] ren_dst_i,
  input  logic [WIDTH-1:0][AW-1:0] ren_src1_i,
  input  logic [WIDTH-1:0][AW-1:0] ren_src2_i,
  input  logic                     rob_full_i,
  input  logic                     iq_full_i,
  output logic                     stall_o,
  output logic                     ren_fire_o,
  output logic [WIDTH-1:0][PW-1:0] ren_src1_tag_o,
  output logic [WIDTH-1:0][PW-1:0] ren_src2_tag_o,
  output logic [WIDTH-1:0][PW-1:0] ren_dst_tag_o,
  output logic [WIDTH-1:0][PW-1:0] ren_old_tag_o,
  output logic [WIDTH-1:0][CW-1:0] ren_ckpt_o,
  input  logic [WIDTH-1:0]         cmt_valid_i,
  input  logic [WIDTH-1:0][AW-1:0] cmt_arch_i,
  input  logic [WIDTH-1:0][PW-1:0] cmt_tag_i,
  input  logic                     br_resolve_i,
  input  logic                     br_mispredict_i,
  input  logic [CW-1:0]            br_ckpt_i,
  input  logic                     recover_i
);
  logic [NUM_ARCH-1:0][PW-1:0] spec_q;
  logic [NUM_PHYS-1:0]         free_q;
  logic [NUM_ARCH-1:0][PW-1:0] map_stage [WIDTH];
  logic [NUM_PHYS-1:0]         free_stage [WIDTH];
  logic [NUM_ARCH-1:0][PW-1:0] cmap_next, rest_map;
  logic [NUM_PHYS-1:0]         freed, recov_free, rest_free;
  logic [WIDTH-1:0]            alloc, br;
  logic                        flush, room_ok, regs_short;

  assign alloc = ren_valid_i & ren_has_dst_i;
  assign br    = ren_valid_i & ren_is_br_i;
  assign flush = recover_i | br_mispredict_i;

  rn_group_chain #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .WIDTH(WIDTH)) u_chain (
    .map_i        (spec_q),
    .free_i       (free_q),
    .alloc_i      (alloc),
    .dst_i        (ren_dst_i),
    .src1_i       (ren_src1_i),
    .src2_i       (ren_src2_i),
    .src1_tag_o   (ren_src1_tag_o),
    .src2_tag_o   (ren_src2_tag_o),
    .dst_tag_o    (ren_dst_tag_o),
    .old_tag_o    (ren_old_tag_o),
    .map_stage_o  (map_stage),
    .free_stage_o (free_stage)
  );

  rn_commit_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .WIDTH(WIDTH)) u_cmap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmt_valid_i  (cmt_valid_i),
    .cmt_arch_i   (cmt_arch_i),
    .cmt_tag_i    (cmt_tag_i),
    .cmap_next_o  (cmap_next),
    .freed_o      (freed),
    .recov_free_o (recov_free)
  );

  rn_ckpt_store #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .WIDTH(WIDTH),
                  .NUM_CKPT(NUM_CKPT)) u_ckpt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (ren_fire_o),
    .br_i         (br),
    .map_stage_i  (map_stage),
    .free_stage_i (free_stage),
    .freed_i      (freed),
    .resolve_i    (br_resolve_i),
    .mispredict_i (br_mispredict_i),
    .mis_id_i     (br_ckpt_i),
    .clear_i      (recover_i),
    .slot_id_o    (ren_ckpt_o),
    .room_ok_o    (room_ok),
    .rest_map_o   (rest_map),
    .rest_free_o  (rest_free)
  );

  assign regs_short = $countones(alloc) > $countones(free_q);
  assign stall_o    = rob_full_i | iq_full_i | regs_short | ~room_ok;
  assign ren_fire_o = ~stall_o & ~flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) spec_q[a] <= PW'(a);
      for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_ARCH);
    end else if (recover_i) begin
      spec_q <= cmap_next;
      free_q <= recov_free;
    end else if (br_mispredict_i) begin
      spec_q <= rest_map;
      free_q <= rest_free | freed;
    end else if (ren_fire_o) begin
      spec_q <= map_stage[WIDTH-1];
      free_q <= free_stage[WIDTH-1] | freed;
    end else begin
      free_q <= free_q | freed;
    end
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_chk
    AST_ALLOC_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ren_fire_o && alloc[k]) |-> free_q[ren_dst_tag_o[k]]); // R3
  end
  AST_HOLD_KEEPS_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !flush) |=> (spec_q == $past(spec_q))); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_full_i || iq_full_i) |-> !ren_fire_o); // R5
  AST_MIS_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_mispredict_i |-> !ren_fire_o); // R7
  AST_NO_DOUBLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((freed & free_q) == '0)); // R8
endmodule

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
  localparam int NA = 32, NP = 64, W = 4, NC = 4;
  localparam int AW = 5, PW = 6, CW = 2, RB = 128;
  localparam int CYCLES = 4000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] ren_valid_i = '0, ren_has_dst_i = '0, ren_is_br_i = '0;
  logic [W-1:0][AW-1:0] ren_dst_i = '0, ren_src1_i = '0, ren_src2_i = '0;
  logic rob_full_i = 1'b0, iq_full_i = 1'b0;
  logic stall_o, ren_fire_o;
  logic [W-1:0][PW-1:0] ren_src1_tag_o, ren_src2_tag_o, ren_dst_tag_o, ren_old_tag_o;
  logic [W-1:0][CW-1:0] ren_ckpt_o;
  logic [W-1:0] cmt_valid_i = '0;
  logic [W-1:0][AW-1:0] cmt_arch_i = '0;
  logic [W-1:0][PW-1:0] cmt_tag_i = '0;
  logic br_resolve_i = 1'b0, br_mispredict_i = 1'b0, recover_i = 1'b0;
  logic [CW-1:0] br_ckpt_i = '0;

  reg_rename u_reg_rename (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int spec[NA], cmap[NA];
  bit fre[NP];
  int ck_map[NC][NA];
  bit ck_free[NC][NP];
  int ck_rob[NC];
  int ck_head = 0, ck_cnt = 0;
  int rob_arch[RB], rob_tag[RB];
  bit rob_br[RB], rob_res[RB];
  int rob_h = 0, rob_t = 0, cmt_pos = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive_random();
    int nc, pos;
    bit stop;
    int r;
    ren_valid_i = '0; ren_has_dst_i = '0; ren_is_br_i = '0;
    for (int k = 0; k < W; k++) begin
      ren_valid_i[k] = ($urandom % 10) < 8;
      r = $urandom % 100;
      ren_is_br_i[k]   = r < 15;
      ren_has_dst_i[k] = r >= 15 && r < 85;
      ren_dst_i[k]  = AW'($urandom % 8);  // small set: frequent intra-group reuse
      ren_src1_i[k] = AW'($urandom % 8);
      ren_src2_i[k] = AW'($urandom % NA);
    end
    rob_full_i = ((rob_t - rob_h) >= RB - 8) || ($urandom % 25 == 0);
    iq_full_i  = ($urandom % 25 == 0);
    // commits in program order, stopping at an unresolved branch
    cmt_valid_i = '0;
    nc = $urandom % (W + 1);
    pos = rob_h; stop = 0;
    for (int k = 0; k < nc; k++) begin
      if (!stop && pos < rob_t) begin
        if (rob_br[pos % RB]) begin
          if (rob_res[pos % RB]) pos++;
          else stop = 1;
        end else begin
          cmt_valid_i[k] = 1'b1;
          cmt_arch_i[k]  = AW'(rob_arch[pos % RB]);
          cmt_tag_i[k]   = PW'(rob_tag[pos % RB]);
          pos++;
        end
      end
    end
    cmt_pos = pos;
    br_resolve_i = 0; br_mispredict_i = 0; recover_i = 0;
    r = $urandom % 100;
    if (r < 2) recover_i = 1;
    else if (r < 10 && ck_cnt > 0) begin
      br_mispredict_i = 1;
      br_ckpt_i = CW'((ck_head + int'($urandom % ck_cnt)) % NC);
    end else if (r < 32 && ck_cnt > 0) br_resolve_i = 1;
  endtask

  task automatic eval_cycle();
    int m[NA];
    bit f[NP];
    int nfree = 0, need = 0, nbr = 0, nb = 0, pick, c;
    int fl[W];
    int nfl = 0;
    bit es, ef;
    #1;
    for (int p = 0; p < NP; p++) nfree += fre[p];
    for (int k = 0; k < W; k++) begin
      if (ren_valid_i[k] && ren_has_dst_i[k]) need++;
      if (ren_valid_i[k] && ren_is_br_i[k]) nbr++;
    end
    es = rob_full_i || iq_full_i || (need > nfree) || (nbr > NC - ck_cnt);
    chk(stall_o == es, "R4 R5 R6 stall", stall_o, es);
    ef = !es && !br_mispredict_i && !recover_i;
    chk(ren_fire_o == ef, "R6 R7 R9 fire", ren_fire_o, ef);
    m = spec; f = fre;
    if (ef) begin
      for (int k = 0; k < W; k++) begin
        if (ren_valid_i[k]) begin
          chk(ren_src1_tag_o[k] == PW'(m[ren_src1_i[k]]), "R2 src1 tag", ren_src1_tag_o[k], m[ren_src1_i[k]]);
          chk(ren_src2_tag_o[k] == PW'(m[ren_src2_i[k]]), "R2 src2 tag", ren_src2_tag_o[k], m[ren_src2_i[k]]);
          if (ren_has_dst_i[k]) begin
            pick = -1;
            for (int p = NP - 1; p >= 0; p--) if (f[p]) pick = p;
            chk(ren_dst_tag_o[k] == PW'(pick), "R3 dst tag", ren_dst_tag_o[k], pick);
            chk(ren_old_tag_o[k] == PW'(m[ren_dst_i[k]]), "R3 old tag", ren_old_tag_o[k], m[ren_dst_i[k]]);
            m[ren_dst_i[k]] = pick; f[pick] = 0;
            rob_arch[rob_t % RB] = ren_dst_i[k]; rob_tag[rob_t % RB] = pick;
            rob_br[rob_t % RB] = 0; rob_res[rob_t % RB] = 0; rob_t++;
          end else begin
            chk(ren_dst_tag_o[k] == '0, "R3 no-alloc tag", ren_dst_tag_o[k], 0);
          end
          if (ren_is_br_i[k]) begin
            c = (ck_head + ck_cnt + nb) % NC; nb++;
            chk(ren_ckpt_o[k] == CW'(c), "R6 ckpt id", ren_ckpt_o[k], c);
            rob_br[rob_t % RB] = 1; rob_res[rob_t % RB] = 0; rob_t++;
            ck_map[c] = m; ck_free[c] = f; ck_rob[c] = rob_t;
          end
        end
      end
    end
    for (int k = 0; k < W; k++) begin
      if (cmt_valid_i[k]) begin
        fl[nfl++] = cmap[cmt_arch_i[k]];
        cmap[cmt_arch_i[k]] = cmt_tag_i[k];
      end
    end
    rob_h = cmt_pos;
    if (recover_i) begin
      spec = cmap;
      for (int p = 0; p < NP; p++) fre[p] = 1;
      for (int a = 0; a < NA; a++) fre[cmap[a]] = 0;
      ck_cnt = 0; rob_t = rob_h;
    end else if (br_mispredict_i) begin
      c = br_ckpt_i;
      spec = ck_map[c]; fre = ck_free[c];
      ck_cnt = (c - ck_head + NC) % NC;
      rob_t = ck_rob[c];
      rob_res[(rob_t - 1) % RB] = 1;
    end else begin
      if (br_resolve_i) begin
        rob_res[(ck_rob[ck_head] - 1) % RB] = 1;
        ck_head = (ck_head + 1) % NC; ck_cnt--;
      end
      if (ef) begin spec = m; fre = f; ck_cnt += nbr; end
    end
    for (int i = 0; i < nfl; i++) begin
      fre[fl[i]] = 1;
      for (int j = 0; j < NC; j++) ck_free[j][fl[i]] = 1;
    end
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin spec[a] = a; cmap[a] = a; end
    for (int p = 0; p < NP; p++) fre[p] = (p >= NA);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset identity and first allocations
    ren_valid_i = '1; ren_has_dst_i = '1; ren_is_br_i = '0;
    for (int k = 0; k < W; k++) begin
      ren_dst_i[k] = AW'(k + 1); ren_src1_i[k] = AW'(10 + k); ren_src2_i[k] = AW'(20 + k);
    end
    #1;
    chk(stall_o == 1'b0, "R1 no stall after reset", stall_o, 0);
    for (int k = 0; k < W; k++) begin
      chk(ren_src1_tag_o[k] == PW'(10 + k), "R1 identity src1", ren_src1_tag_o[k], 10 + k);
      chk(ren_src2_tag_o[k] == PW'(20 + k), "R1 identity src2", ren_src2_tag_o[k], 20 + k);
      chk(ren_dst_tag_o[k] == PW'(NA + k), "R1 first free tags", ren_dst_tag_o[k], NA + k);
    end
    cmt_pos = rob_h;
    eval_cycle();
    for (int n = 0; n < CYCLES; n++) begin
      @(negedge clk_i);
      drive_random();
      eval_cycle();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * (CYCLES + 100));
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule